// File: doc/BRIEF.md
# Paged Management-Register Bridge

This block sits behind an already-decoded Clause 22 management port on the switch side. It answers at a single PHY address and offers a handful of 16-bit registers there. Through these registers a host reaches a wider internal register space: one register selects an 8-bit page, another names an 8-bit offset and issues the command, and four registers together form a 64-bit data window.

To write an internal register, the host loads the data window first. It then writes the command register with the write bit set. To read one, it writes the command register with the read bit set, polls until the bit drops, and then reads the window. The command bits double as busy flags. They stay set for a fixed access latency, given as a parameter.

The internal side has a fixed latency. The addressed register must present its read data before the last cycle of the request. The page setting stays in force until it is rewritten.

Top module: `pphy_bridge`

## Requirements
- R1: Only frames whose PHY address equals `PHY_ADDR` (default 5'h1E) are acted on. A write to any other address changes no state, and a read to any other address leaves `mg_rdata` unchanged.
- R2: Register 5'h10 holds the page in bits 15:8 and an enable flag in bit 0, and bits 7:1 read as 0. The page stays in force across any number of transfers.
- R3: Register 5'h11 holds the internal offset in bits 15:8, the write command in bit 0 and the read command in bit 1. If both bits are written as 1, only the read is performed and only bit 1 reads back as 1.
- R4: A command write starts a transfer. `ib_req` and the command bit are then high for exactly `ACC_LAT` cycles, starting the cycle after the write is sampled. After that both read back 0.
- R5: Registers 5'h18 to 5'h1B form the data window, with 5'h18 holding bits 15:0 and each next register holding the next 16 bits. A write transfer drives the window onto `ib_wdata`.
- R6: When a read transfer ends, the window is loaded with `ib_rdata`, least significant 16 bits in register 5'h18.
- R7: A command write while the page enable bit is 0 stores the offset but starts no transfer: `ib_req` stays low and the command bits read 0.
- R8: While a transfer is busy, writes to the page, command and window registers are ignored. `ib_page`, `ib_off` and `ib_wdata` hold steady during the transfer.
- R9: Reads of any other register number at the block's address return 16'h0000, and writes to them have no effect.
- R10: After synchronous reset, all registers are 0, `ib_req` is low and `mg_rdata` is 0.
- R11: `mg_rdata` takes the addressed value on the clock edge that samples `mg_re`, and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mg_phy | input | 5 | PHY address of the decoded frame |
| mg_reg | input | 5 | Register number of the decoded frame |
| mg_we | input | 1 | Write strobe, one cycle |
| mg_wdata | input | 16 | Write data |
| mg_re | input | 1 | Read strobe, one cycle |
| mg_rdata | output | 16 | Registered read data |
| ib_req | output | 1 | Internal transfer in progress |
| ib_we | output | 1 | Internal transfer is a write |
| ib_page | output | 8 | Internal page |
| ib_off | output | 8 | Internal offset |
| ib_wdata | output | 64 | Internal write data (data window) |
| ib_rdata | input | 64 | Internal read data, valid by the last busy cycle |

## Verification
A register write takes effect on the edge that samples its strobe. A read result is visible in `mg_rdata` just after the edge that samples `mg_re`, so the bench drives a strobe at one falling edge and reads the result at the next one. The busy window opens one cycle after the command edge and lasts `ACC_LAT` cycles. The bench counts `ib_req` at falling edges over a longer span and expects exactly that count. It waits `ACC_LAT`+2 cycles before reading the window. The test of writes ignored while busy places its strobes on known edges that fall inside the busy window.

// File: rtl/pphy_pkg.sv
package pphy_pkg;

    localparam logic [4:0] REG_PAGE = 5'h10;
    localparam logic [4:0] REG_CMD  = 5'h11;
    localparam logic [4:0] REG_WIN0 = 5'h18;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PAGE = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_WIN  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] num;
        logic       en;
    } page_t;

    typedef struct packed {
        logic [7:0] off;
        logic       rd;
        logic       wr;
    } cmd_t;

    function automatic reg_sel_e decode_reg(input logic [4:0] r, input int unsigned nwin);
        logic [5:0] top;
        top = {1'b0, REG_WIN0} + 6'(nwin);
        if (r == REG_PAGE)                                return SEL_PAGE;
        if (r == REG_CMD)                                 return SEL_CMD;
        if (r >= REG_WIN0 && {1'b0, r} < top)             return SEL_WIN;
        return SEL_NONE;
    endfunction

    function automatic logic [15:0] pack_page(input page_t p);
        return {p.num, 7'b0, p.en};
    endfunction

    function automatic logic [15:0] pack_cmd(input cmd_t c);
        return {c.off, 6'b0, c.rd, c.wr};
    endfunction

endpackage

// File: rtl/pphy_decode.sv
module pphy_decode
    import pphy_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'h1E,
    parameter int unsigned NWIN    = 4,
    localparam int unsigned IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [4:0]       phy,
    input  logic [4:0]       regno,
    input  logic             we,
    input  logic             re,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] win_idx,
    output logic             hit_we,
    output logic             hit_re
);
    logic       match;
    logic [4:0] rel;

    always_comb begin
        match   = (phy == PHY_ADDR);
        hit_we  = we && match;
        hit_re  = re && match;
        sel     = decode_reg(regno, NWIN);
        rel     = regno - REG_WIN0;
        win_idx = rel[IDX_W-1:0];
    end
endmodule

// File: rtl/pphy_xfer.sv
module pphy_xfer #(
    parameter int unsigned ACC_LAT = 4,
    localparam int unsigned CNT_W  = $clog2(ACC_LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_wr,
    input  logic start_rd,
    output logic busy,
    output logic cmd_rd,
    output logic cmd_wr,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cmd_rd <= 1'b0;
            cmd_wr <= 1'b0;
        end else if (!busy && (start_rd || start_wr)) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(ACC_LAT);
            cmd_rd <= start_rd;
            cmd_wr <= start_wr && !start_rd;
        end else if (busy) begin
            if (cnt == CNT_W'(1)) begin
                busy   <= 1'b0;
                cnt    <= '0;
                cmd_rd <= 1'b0;
                cmd_wr <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assign done = busy && (cnt == CNT_W'(1));

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_rd, cmd_wr}));                                     // R3
    AST_BUSY_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cmd_rd || cmd_wr));                                    // R4
    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(cmd_rd || cmd_wr));                                  // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt != '0 && cnt <= CNT_W'(ACC_LAT)));                 // R4
endmodule

// File: rtl/pphy_window.sv
module pphy_window #(
    parameter int unsigned NWIN   = 4,
    localparam int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int unsigned FLAT_W = NWIN * 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [15:0]       wr_data,
    input  logic              cap,
    input  logic [FLAT_W-1:0] cap_data,
    output logic [FLAT_W-1:0] win_flat
);
    for (genvar g = 0; g < NWIN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                win_flat[g*16 +: 16] <= '0;
            else if (cap)
                win_flat[g*16 +: 16] <= cap_data[g*16 +: 16];
            else if (wr_en && wr_idx == IDX_W'(g))
                win_flat[g*16 +: 16] <= wr_data;
        end
    end
endmodule

// File: rtl/pphy_bridge.sv
module pphy_bridge
    import pphy_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'h1E,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ACC_LAT = 4,
    localparam int unsigned NWIN   = DATA_W / 16,
    localparam int unsigned IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mg_phy,
    input  logic [4:0]        mg_reg,
    input  logic              mg_we,
    input  logic [15:0]       mg_wdata,
    input  logic              mg_re,
    output logic [15:0]       mg_rdata,
    output logic              ib_req,
    output logic              ib_we,
    output logic [7:0]        ib_page,
    output logic [7:0]        ib_off,
    output logic [DATA_W-1:0] ib_wdata,
    input  logic [DATA_W-1:0] ib_rdata
);
    reg_sel_e         sel;
    logic [IDX_W-1:0] win_idx;
    logic             hit_we, hit_re, wr_ok;
    logic             busy, cmd_rd, cmd_wr, done;
    logic             start_rd, start_wr;
    page_t            page_q;
    logic [7:0]       off_q;
    logic [DATA_W-1:0] win_flat;
    logic [15:0]      rd_val;
    cmd_t             cmd_view;

    pphy_decode #(.PHY_ADDR(PHY_ADDR), .NWIN(NWIN)) u_dec (
        .phy(mg_phy), .regno(mg_reg), .we(mg_we), .re(mg_re),
        .sel(sel), .win_idx(win_idx), .hit_we(hit_we), .hit_re(hit_re)
    );

    assign wr_ok    = hit_we && !busy;
    assign start_rd = wr_ok && sel == SEL_CMD && page_q.en && mg_wdata[1];
    assign start_wr = wr_ok && sel == SEL_CMD && page_q.en && mg_wdata[0];

    pphy_xfer #(.ACC_LAT(ACC_LAT)) u_xfer (
        .clk(clk), .rst(rst), .start_wr(start_wr), .start_rd(start_rd),
        .busy(busy), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .done(done)
    );

    pphy_window #(.NWIN(NWIN)) u_win (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok && sel == SEL_WIN), .wr_idx(win_idx), .wr_data(mg_wdata),
        .cap(done && cmd_rd), .cap_data(ib_rdata), .win_flat(win_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_PAGE) page_q <= '{num: mg_wdata[15:8], en: mg_wdata[0]};
            if (sel == SEL_CMD)  off_q  <= mg_wdata[15:8];
        end
    end

    always_comb begin
        cmd_view = '{off: off_q, rd: cmd_rd, wr: cmd_wr};
        case (sel)
            SEL_PAGE: rd_val = pack_page(page_q);
            SEL_CMD:  rd_val = pack_cmd(cmd_view);
            SEL_WIN:  rd_val = win_flat[win_idx*16 +: 16];
            default:  rd_val = 16'h0000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         mg_rdata <= '0;
        else if (hit_re) mg_rdata <= rd_val;
    end

    assign ib_req   = busy;
    assign ib_we    = cmd_wr;
    assign ib_page  = page_q.num;
    assign ib_off   = off_q;
    assign ib_wdata = win_flat;

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(ib_req) |-> page_q.en);                                    // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ib_req && $past(ib_req)) |-> ($stable(ib_page) && $stable(ib_off))); // R8
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !done) |=> $stable(ib_wdata));                        // R8
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mg_we && mg_phy != PHY_ADDR) |=> ($stable(page_q) && $stable(off_q))); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(mg_re && mg_phy == PHY_ADDR) |=> $stable(mg_rdata));           // R11
endmodule

// File: tb/tb_pphy_bridge.sv
module tb_pphy_bridge;
    localparam int LAT = 4;
    localparam logic [4:0] ME = 5'h1E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mg_phy = '0, mg_reg = '0;
    logic        mg_we = 1'b0, mg_re = 1'b0;
    logic [15:0] mg_wdata = '0, mg_rdata;
    logic        ib_req, ib_we;
    logic [7:0]  ib_page, ib_off;
    logic [63:0] ib_wdata, ib_rdata;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pphy_bridge #(.PHY_ADDR(ME), .DATA_W(64), .ACC_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_we(mg_we),
        .mg_wdata(mg_wdata), .mg_re(mg_re), .mg_rdata(mg_rdata),
        .ib_req(ib_req), .ib_we(ib_we), .ib_page(ib_page), .ib_off(ib_off),
        .ib_wdata(ib_wdata), .ib_rdata(ib_rdata)
    );

    // internal register space model, indexed by {page[1:0], off[1:0]}
    logic [63:0] mem [16];
    wire  [3:0]  midx = {ib_page[1:0], ib_off[1:0]};
    assign ib_rdata = mem[midx];
    always @(posedge clk) if (ib_req && ib_we) mem[midx] <= ib_wdata;

    function automatic logic [63:0] seed(input int i);
        return {16'hC0D0 + 16'(i), 16'hB000 + 16'(i), 16'hA000 + 16'(i), 16'h9000 + 16'(i)};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic mwrite(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        mg_phy = phy; mg_reg = r; mg_wdata = d; mg_we = 1'b1;
        @(negedge clk);
        mg_we = 1'b0;
    endtask

    task automatic mread(input logic [4:0] phy, input logic [4:0] r, output logic [15:0] d);
        @(negedge clk);
        mg_phy = phy; mg_reg = r; mg_re = 1'b1;
        @(negedge clk);
        d = mg_rdata;
        mg_re = 1'b0;
    endtask

    task automatic wait_xfer();
        repeat (LAT + 2) @(negedge clk);
    endtask

    // vector: {op[1:0], reg[4:0], data[15:0]}; op 0 write, 1 read-compare, 2 wait
    localparam int NV = 22;
    localparam logic [22:0] VEC [NV] = '{
        {2'd0, 5'h10, 16'h0201},   // R2 page 2 enabled
        {2'd1, 5'h10, 16'h0201},   // R2 readback
        {2'd0, 5'h11, 16'h0302},   // R3 read offset 3
        {2'd2, 5'h00, 16'h0000},
        {2'd1, 5'h11, 16'h0300},   // R4 bits cleared
        {2'd1, 5'h18, 16'h900B},   // R6
        {2'd1, 5'h19, 16'hA00B},   // R6
        {2'd1, 5'h1A, 16'hB00B},   // R6
        {2'd1, 5'h1B, 16'hC0DB},   // R6
        {2'd0, 5'h11, 16'h0102},   // R2 same page, no page write
        {2'd2, 5'h00, 16'h0000},
        {2'd1, 5'h18, 16'h9009},   // R2 R6
        {2'd1, 5'h1B, 16'hC0D9},   // R2 R6
        {2'd0, 5'h18, 16'h1234},   // R5
        {2'd1, 5'h18, 16'h1234},   // R5
        {2'd0, 5'h11, 16'h0101},   // R5 write offset 1
        {2'd2, 5'h00, 16'h0000},
        {2'd0, 5'h18, 16'h0000},
        {2'd0, 5'h11, 16'h0102},   // read offset 1 back
        {2'd2, 5'h00, 16'h0000},
        {2'd1, 5'h18, 16'h1234},   // R5 internal write landed
        {2'd1, 5'h19, 16'hA009}    // R5
    };
    localparam string VTAG [NV] = '{"R2","R2","R3","-","R4","R6","R6","R6","R6","R2","-",
                                    "R6","R6","R5","R5","R5","-","R5","R5","-","R5","R5"};

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rv, hold;
        int cnt;
        for (int i = 0; i < 16; i++) mem[i] = seed(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10", {48'd0, mg_rdata}, 64'd0);
        check("R10", {63'd0, ib_req}, 64'd0);
        mread(ME, 5'h10, rv); check("R10", {48'd0, rv}, 64'd0);
        mread(ME, 5'h18, rv); check("R10", {48'd0, rv}, 64'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [4:0]  r;
            logic [15:0] d;
            {op, r, d} = VEC[v];
            case (op)
                2'd0: mwrite(ME, r, d);
                2'd1: begin mread(ME, r, rv); check(VTAG[v], {48'd0, rv}, {48'd0, d}); end
                default: wait_xfer();
            endcase
        end
        check("R5", mem[9], {16'hC0D9, 16'hB009, 16'hA009, 16'h1234});

        // R4 busy length, read command page 2 offset 3
        mwrite(ME, 5'h11, 16'h0302);
        cnt = 0;
        for (int k = 0; k < LAT + 3; k++) begin
            if (ib_req) cnt++;
            @(negedge clk);
        end
        check("R4", 64'(cnt), 64'(LAT));

        // R3 both bits set: read only
        mwrite(ME, 5'h11, 16'h0303);
        check("R3", {63'd0, ib_we}, 64'd0);
        mread(ME, 5'h11, rv); check("R3", {48'd0, rv}, 64'h0302);
        wait_xfer();
        mread(ME, 5'h11, rv); check("R4", {48'd0, rv}, 64'h0300);

        // R8 writes while busy are ignored (strobes at edges E+2 and E+4)
        mwrite(ME, 5'h11, 16'h0302);
        mwrite(ME, 5'h11, 16'h0001);
        mwrite(ME, 5'h19, 16'hFFFF);
        wait_xfer();
        mread(ME, 5'h11, rv); check("R8", {48'd0, rv}, 64'h0300);
        mread(ME, 5'h19, rv); check("R8", {48'd0, rv}, 64'hA00B);
        mwrite(ME, 5'h11, 16'h0302);
        mwrite(ME, 5'h10, 16'h0501);
        wait_xfer();
        mread(ME, 5'h10, rv); check("R8", {48'd0, rv}, 64'h0201);

        // R7 enable clear: no transfer
        mwrite(ME, 5'h10, 16'h02FE);
        mread(ME, 5'h10, rv); check("R2", {48'd0, rv}, 64'h0200);
        mwrite(ME, 5'h11, 16'h0102);
        check("R7", {63'd0, ib_req}, 64'd0);
        mread(ME, 5'h11, rv); check("R7", {48'd0, rv}, 64'h0100);
        mwrite(ME, 5'h10, 16'h0201);

        // R1 foreign address
        mwrite(5'h01, 5'h10, 16'h0701);
        mwrite(5'h01, 5'h11, 16'h0402);
        check("R1", {63'd0, ib_req}, 64'd0);
        mread(ME, 5'h10, rv); check("R1", {48'd0, rv}, 64'h0201);
        hold = rv;
        mread(5'h01, 5'h11, rv); check("R1", {48'd0, rv}, {48'd0, hold});

        // R9 unimplemented registers
        mwrite(ME, 5'h05, 16'hFFFF);
        mread(ME, 5'h05, rv); check("R9", {48'd0, rv}, 64'd0);
        mread(ME, 5'h12, rv); check("R9", {48'd0, rv}, 64'd0);
        mread(ME, 5'h10, rv); check("R9", {48'd0, rv}, 64'h0201);

        // R11 read data holds without a read strobe
        mread(ME, 5'h10, rv);
        repeat (3) @(negedge clk);
        check("R11", {48'd0, mg_rdata}, 64'h0201);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule